// File: doc/BRIEF.md
# Banked Sample Store for Parallel Correlator Reads

This block holds received baseband samples for a group of despreading correlators that work on the same code channel. One stored word carries four complex samples of 24 bits each, so every access moves 96 bits. Word addresses are interleaved across sixteen banks by their low address bits. Each bank can produce one word per clock, so four correlator ports that look at different time offsets of the same sample stream are all served in one cycle as long as their words lie in different banks.

Each correlator port presents a request and a word address. A port whose request is accepted sees its grant in that cycle and its data, with a valid flag, on the next cycle. When several ports hit the same bank, the lowest-numbered port is served and the others keep their request up until their turn. A single write port loads new words. It gives way to any read of the same bank, and signals the stall through a ready output.

Top module: `sample_bank_mem`

## Requirements
- R1: A word written at address A is returned unchanged on a read of A. Sample k of the word occupies bits [24k+23:24k] of the 96-bit word, for k from 0 to 3.
- R2: The bank of word address A is A modulo 16 (the low four address bits). The remaining upper bits pick the row inside that bank, so 16 consecutive addresses occupy 16 different banks.
- R3: In one cycle, all requesting ports whose addresses fall in pairwise different banks are granted together.
- R4: When two or more requesting ports share a bank in a cycle, only the lowest-numbered of them is granted. The others get no grant and no valid flag for that cycle. If a losing port keeps requesting, it is granted in a later cycle, and a set of N ports that all collide is fully served in N cycles.
- R5: A port's valid output is high in exactly the cycles that follow a cycle in which that port was granted, and its read data is meaningful in those cycles.
- R6: The write ready output is low exactly when some port requests a read of the bank that the write address selects. A write presented with ready low leaves the memory unchanged. A write presented with ready high stores its word.
- R7: Reset forces every valid output low and leaves the stored words intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 4 | Read request, one bit per correlator port |
| rd_addr | input | 32 | Word address per port, port p in bits [8p+7:8p] |
| rd_gnt | output | 4 | Request accepted this cycle, per port |
| rd_valid | output | 4 | Read data valid, per port |
| rd_data | output | 384 | Read word per port, port p in bits [96p+95:96p] |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 96 | Write word |
| wr_ready | output | 1 | Write is taken this cycle if wr_en is high |

## Verification
A read and a write can both target one bank in the same cycle, and reads from several ports can also land on one bank together. The bench sweeps every base address against every port spacing from 0 to 15 with changing request masks. Alongside that, it runs writes whose addresses walk across the banks, so collisions between reads, and between reads and the write, arise in many combinations. Grants, write ready, valid flags and returned words are judged against a bank-modulo arbitration model and a shadow copy of memory that takes only the writes the model accepts. A stalled write that a later read still returns as the old word is the direct evidence of the yield rule.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  // Default geometry of the sample store
  localparam int SAMPLE_W         = 24;
  localparam int SAMPLES_PER_WORD = 4;
  localparam int WORD_W           = SAMPLE_W * SAMPLES_PER_WORD;
  localparam int DEF_NPORTS       = 4;
  localparam int DEF_NBANKS       = 16;
  localparam int DEF_ADDR_W       = 8;

  // Rule on geometry: banks must exceed twice the port count
  function automatic bit geometry_ok(int nports, int nbanks);
    return (nbanks > 2 * nports) && ((nbanks & (nbanks - 1)) == 0);
  endfunction
endpackage

// File: rtl/sbm_bank_arb.sv
module sbm_bank_arb #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] req,
  input  logic              wr_hit,
  output logic [NPORTS-1:0] gnt,
  output logic              rd_busy,
  output logic              wr_go
);

  logic [NPORTS-1:0] gnt_c;
  logic              taken_c;

  // Fixed priority: the lowest index among requesters wins
  always_comb begin
    gnt_c   = '0;
    taken_c = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      if (req[p] && !taken_c) begin
        gnt_c[p] = 1'b1;
        taken_c  = 1'b1;
      end
    end
  end

  assign gnt     = gnt_c;
  assign rd_busy = taken_c;
  assign wr_go   = wr_hit && !taken_c;

  assert_one_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  assert_bank_not_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

  assert_write_yields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> (req == '0));

  for (genvar q = 1; q < NPORTS; q++) begin : g_prio_chk
    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[q] |-> ($countones(req[q-1:0]) == 0));
  end

endmodule

// File: rtl/sbm_bank.sv
module sbm_bank #(
  parameter int NPORTS = 4,
  parameter int ROW_W  = 4,
  parameter int WORD_W = 96
) (
  input  logic                    clk,
  input  logic [NPORTS-1:0]       gnt,
  input  logic [NPORTS*ROW_W-1:0] rows,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [WORD_W-1:0]       dout
);

  localparam int ROWS = 1 << ROW_W;

  logic [WORD_W-1:0] mem [ROWS];
  logic [WORD_W-1:0] dout_q;
  logic [ROW_W-1:0]  rd_row_c;

  // Row of whichever port holds this bank's grant
  always_comb begin
    rd_row_c = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (gnt[p]) rd_row_c = rd_row_c | rows[p*ROW_W +: ROW_W];
    end
  end

  // Storage and output register carry no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) dout_q <= mem[rd_row_c];
  end

  assign dout = dout_q;

endmodule

// File: rtl/sbm_port_ret.sv
module sbm_port_ret #(
  parameter int NBANKS = 16,
  parameter int BANK_W = 4,
  parameter int WORD_W = 96
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gnt,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic [NBANKS*WORD_W-1:0] bank_dout,
  output logic                     valid,
  output logic [WORD_W-1:0]        data
);

  logic              valid_q, valid_d;
  logic [BANK_W-1:0] sel_q, sel_d;
  logic              sel_en;

  // Next-state
  always_comb begin
    valid_d = gnt;
    sel_en  = gnt;
    sel_d   = bank_sel;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  assign valid = valid_q;
  assign data  = bank_dout[sel_q*WORD_W +: WORD_W];

  assert_valid_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(gnt));

endmodule

// File: rtl/sample_bank_mem.sv
module sample_bank_mem #(
  parameter int NPORTS = sbm_pkg::DEF_NPORTS,
  parameter int NBANKS = sbm_pkg::DEF_NBANKS,
  parameter int ADDR_W = sbm_pkg::DEF_ADDR_W,
  parameter int WORD_W = sbm_pkg::WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        rd_req,
  input  logic [NPORTS*ADDR_W-1:0] rd_addr,
  output logic [NPORTS-1:0]        rd_gnt,
  output logic [NPORTS-1:0]        rd_valid,
  output logic [NPORTS*WORD_W-1:0] rd_data,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  output logic                     wr_ready
);

  localparam int BANK_W = $clog2(NBANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam bit GEO_OK = sbm_pkg::geometry_ok(NPORTS, NBANKS);

  logic [BANK_W-1:0]        port_bank [NPORTS];
  logic [NPORTS*ROW_W-1:0]  port_rows;
  logic [NPORTS-1:0]        gnt_m [NBANKS];
  logic [NBANKS-1:0]        bank_busy;
  logic [NBANKS-1:0]        bank_wr_go;
  logic [NBANKS*WORD_W-1:0] bank_dout;
  logic [BANK_W-1:0]        wr_bank;
  logic [ROW_W-1:0]         wr_row;

  // Address split: low bits pick the bank, upper bits the row
  for (genvar p = 0; p < NPORTS; p++) begin : g_split
    assign port_bank[p] = rd_addr[p*ADDR_W +: BANK_W];
    assign port_rows[p*ROW_W +: ROW_W] = rd_addr[p*ADDR_W+BANK_W +: ROW_W];
  end

  assign wr_bank = wr_addr[BANK_W-1:0];
  assign wr_row  = wr_addr[ADDR_W-1:BANK_W];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [NPORTS-1:0] breq;
    logic              bwr_hit;

    always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
        breq[p] = rd_req[p] && (port_bank[p] == BANK_W'(b));
      end
      bwr_hit = wr_en && (wr_bank == BANK_W'(b));
    end

    sbm_bank_arb #(
      .NPORTS (NPORTS)
    ) i_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (breq),
      .wr_hit  (bwr_hit),
      .gnt     (gnt_m[b]),
      .rd_busy (bank_busy[b]),
      .wr_go   (bank_wr_go[b])
    );

    sbm_bank #(
      .NPORTS (NPORTS),
      .ROW_W  (ROW_W),
      .WORD_W (WORD_W)
    ) i_bank (
      .clk     (clk),
      .gnt     (gnt_m[b]),
      .rows    (port_rows),
      .rd_en   (bank_busy[b]),
      .wr_en   (bank_wr_go[b]),
      .wr_row  (wr_row),
      .wr_data (wr_data),
      .dout    (bank_dout[b*WORD_W +: WORD_W])
    );
  end

  // Collect per-port grants from all banks
  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      rd_gnt[p] = 1'b0;
      for (int b = 0; b < NBANKS; b++) begin
        rd_gnt[p] = rd_gnt[p] | gnt_m[b][p];
      end
    end
  end

  assign wr_ready = !bank_busy[wr_bank];

  for (genvar p = 0; p < NPORTS; p++) begin : g_ret
    sbm_port_ret #(
      .NBANKS (NBANKS),
      .BANK_W (BANK_W),
      .WORD_W (WORD_W)
    ) i_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt       (rd_gnt[p]),
      .bank_sel  (port_bank[p]),
      .bank_dout (bank_dout),
      .valid     (rd_valid[p]),
      .data      (rd_data[p*WORD_W +: WORD_W])
    );

    assert_write_other_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ready && rd_req[p]) |-> (port_bank[p] != wr_bank));
  end

  assert_port0_never_loses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[0] |-> rd_gnt[0]);

  assert_no_stray_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_valid == '0));

  always_comb begin
    assert_geometry_R3: assert (GEO_OK);
  end

endmodule

// File: tb/test_sample_bank_mem.sv
`timescale 1ns/1ps
module test_sample_bank_mem;

  localparam int NP = 4;
  localparam int AW = 8;
  localparam int WW = 96;
  localparam int NW = 256;

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   rd_req;
  logic [NP*AW-1:0] rd_addr;
  logic [NP-1:0]   rd_gnt;
  logic [NP-1:0]   rd_valid;
  logic [NP*WW-1:0] rd_data;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic [WW-1:0]   wr_data;
  logic            wr_ready;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [WW-1:0] shadow [NW];

  sample_bank_mem i_sample_bank_mem (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [WW-1:0] pattern(int a, int gen);
    logic [WW-1:0] w;
    for (int k = 0; k < 4; k++)
      w[k*24 +: 24] = {8'(a), 4'(k), 4'(gen), 8'(a*7 + k*13 + gen*29)};
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus with full checking against the model
  task automatic cycle(input logic [NP-1:0] req, input logic [NP*AW-1:0] addrs,
                       input logic we, input logic [AW-1:0] wa, input logic [WW-1:0] wd);
    logic [NP-1:0] eg;
    logic          er;
    @(negedge clk);
    rd_req = req; rd_addr = addrs; wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    eg = '0;
    er = 1'b1;
    for (int p = 0; p < NP; p++) begin
      logic lose;
      lose = 1'b0;
      for (int q = 0; q < p; q++)
        if (req[q] && (addrs[q*AW +: 4] == addrs[p*AW +: 4])) lose = 1'b1;
      if (req[p] && !lose) eg[p] = 1'b1;
      if (req[p] && (addrs[p*AW +: 4] == wa[3:0])) er = 1'b0;
    end
    check(rd_gnt == eg, "R3/R4 grant", WW'(rd_gnt), WW'(eg));
    check(wr_ready == er, "R6 write ready", WW'(wr_ready), WW'(er));
    @(posedge clk);
    #1;
    check(rd_valid == eg, "R5 valid", WW'(rd_valid), WW'(eg));
    for (int p = 0; p < NP; p++)
      if (eg[p])
        check(rd_data[p*WW +: WW] === shadow[addrs[p*AW +: AW]], "R1/R2 data",
              rd_data[p*WW +: WW], shadow[addrs[p*AW +: AW]]);
    if (we && er) shadow[wa] = wd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] mask;
    logic [NP*AW-1:0] ad;
    int n;
    rst_n = 1'b0; rd_req = '0; rd_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(rd_valid == '0, "R7 reset valid", WW'(rd_valid), '0);
    rst_n = 1'b1;

    // Load every word, no reads so every write must be ready
    for (int a = 0; a < NW; a++) begin
      shadow[a] = 'x;
      cycle('0, '0, 1'b1, AW'(a), pattern(a, 0));
    end

    // R3: four consecutive addresses, four different banks
    ad = {8'd3, 8'd2, 8'd1, 8'd0};
    cycle(4'hF, ad, 1'b0, '0, '0);
    check(rd_gnt == 4'hF, "R3 all distinct served", WW'(rd_gnt), WW'(4'hF));

    // R4: four ports in one bank drain in four cycles
    ad = {8'd53, 8'd37, 8'd21, 8'd5};
    mask = 4'hF; n = 0;
    while (mask != 0 && n < 8) begin
      cycle(mask, ad, 1'b0, '0, '0);
      mask = mask & ~rd_valid;
      n++;
    end
    check(n == 4, "R4 drain cycles", WW'(n), WW'(4));

    // R6: stalled write must leave the old word in place
    ad = {8'd0, 8'd0, 8'd0, 8'd5};
    cycle(4'h1, ad, 1'b1, 8'd21, pattern(21, 9));
    check(wr_ready == 1'b0, "R6 stall seen", WW'(wr_ready), '0);
    ad = {8'd0, 8'd0, 8'd0, 8'd21};
    cycle(4'h1, ad, 1'b0, '0, '0);
    check(rd_data[0 +: WW] == pattern(21, 0), "R6 old word kept",
          rd_data[0 +: WW], pattern(21, 0));

    // Sweep all bases and spacings, with writes walking the banks
    for (int d = 0; d < 16; d++) begin
      for (int base = 0; base < NW; base++) begin
        for (int p = 0; p < NP; p++) ad[p*AW +: AW] = AW'(base + p*d);
        mask = 4'(base ^ d) | 4'(base == 0);
        cycle(mask, ad, base[0], AW'(base*5 + d), pattern(base*5 + d, 1 + d));
      end
    end

    // R7: reset with a request pending, memory must survive
    @(negedge clk);
    rd_req = 4'hF; rd_addr = {8'd7, 8'd6, 8'd5, 8'd4}; wr_en = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check(rd_valid == '0, "R7 valid cleared", WW'(rd_valid), '0);
    @(negedge clk);
    rd_req = '0;
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) begin
      ad = {AW'(a*16 + 3), AW'(a*16 + 2), AW'(a*16 + 1), AW'(a*16)};
      cycle(4'hF, ad, 1'b0, '0, '0);
    end
    cycle('0, '0, 1'b0, '0, '0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule